// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a clocked single-port memory model for testbenches and emulation. On every rising clock edge it samples a command made of chip enable, write enable and an address. A read returns its word on a dedicated output bus a fixed number of cycles later, called the access latency. The last step of the read path is an output register.

A write does not take its data on the edge that accepts the command. The write data goes on a separate input bus and is sampled exactly one access latency after the command. That is the same slot a read issued on the same edge would use on the output bus. Because both directions use the same slot, any mix of reads and writes can be issued on consecutive cycles without idle cycles.

Writes whose data has not yet arrived are held in a short command pipeline together with their address. A read issued while a write to the same address is still in that pipeline returns the newer data when that data arrives, not the stale array contents. A valid strobe marks each cycle that carries a read result.

Top module: `zbt_sram`

## Requirements
- R1: A command is taken only on an edge where `ce` is 1. With `ce` at 0 there is no write to the array and no later `rd_valid` pulse, whatever `we`, `addr` and `wr_data` carry.
- R2: A read (`ce`=1, `we`=0) sampled at edge E sets `rd_valid` to 1 and places the word on `rd_data` after edge E+LAT. `rd_valid` is 1 for that one cycle only (LAT=2 by default).
- R3: For a write (`ce`=1, `we`=1) sampled at edge E, the stored word is the value of `wr_data` at edge E+LAT, not its value at edge E.
- R4: A read returns the word of the most recent earlier write to its address, in command order.
- R5: Reads and writes can be issued on every cycle in any order. Each read produces its result exactly LAT cycles after issue, and no result is lost or reordered.
- R6: A read issued while an earlier write to the same address still waits for its data returns that write's data.
- R7: `wr_data` on an edge where no write is due has no effect on the memory contents.
- R8: While `rst_n` is 0 and after reset, before any read completes, `rd_valid` is 0 and `rd_data` is 0.
- R9: `rd_data` keeps its last value in every cycle where `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Chip enable; a command is accepted only when 1 |
| we | input | 1 | 1 = write command, 0 = read command |
| addr | input | AW | Word address of the command |
| wr_data | input | DW | Write data, sampled LAT edges after its write command |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | 1 in the cycle that carries a read result |

## Verification
The assertions assume that `rst_n` is low on the first clock edge. They also assume that every input is driven to a known level whenever `rst_n` is high, because the forwarding check compares stored words against the sampled `wr_data`. The bench resets for several cycles before issuing commands and drives all inputs from the falling edge. On cycles where no write is due, it puts a changing filler pattern on `wr_data`, so any stray capture shows up in a later read. It writes every address before reading any of them, so every read has a defined expected word.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  // Smallest access latency the forwarding pipeline supports
  localparam int unsigned MIN_LAT = 2;

  typedef enum logic [0:0] {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // A stage slot holds a read command
  function automatic logic slot_is_read(input logic vld, input logic wr);
    return vld & (wr == OP_READ);
  endfunction

  // A stage slot holds a write command
  function automatic logic slot_is_write(input logic vld, input logic wr);
    return vld & (wr == OP_WRITE);
  endfunction

endpackage

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
  import zbt_sram_pkg::*;
#(
  parameter int unsigned AW  = 6,
  parameter int unsigned LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  output logic [LAT-1:0]         st_vld,
  output logic [LAT-1:0]         st_wr,
  output logic [LAT-1:0][AW-1:0] st_addr
);

  // Stage 0 captures the command on the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_vld[0] <= 1'b0;
      st_wr[0]  <= 1'b0;
    end else begin
      st_vld[0] <= ce;
      st_wr[0]  <= we;
    end
    st_addr[0] <= addr;
  end

  // Later stages shift the command one slot per edge, never stalling
  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_vld[i] <= 1'b0;
        st_wr[i]  <= 1'b0;
      end else begin
        st_vld[i] <= st_vld[i-1];
        st_wr[i]  <= st_wr[i-1];
      end
      st_addr[i] <= st_addr[i-1];
    end

    // R5: a command advances every edge, nothing is held back
    assert_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld[i-1] |=> st_vld[i]);
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [DW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_raddr,
  output logic [DW-1:0] mem_rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we) cells[mem_waddr] <= mem_wdata;
  end

  // Combinational sense path; the consumer registers it
  assign mem_rdata = cells[mem_raddr];

endmodule

// File: rtl/zbt_read_track.sv
module zbt_read_track
  import zbt_sram_pkg::*;
#(
  parameter int unsigned AW  = 6,
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LAT-1:0]         st_vld,
  input  logic [LAT-1:0]         st_wr,
  input  logic [LAT-1:0][AW-1:0] st_addr,
  input  logic                   commit,
  input  logic [AW-1:0]          commit_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [DW-1:0]          arr_rdata,
  output logic [LAT-1:1]         fwd_hit,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_valid
);

  // Data carried alongside each read as it travels through stages 1..LAT-1
  logic [LAT-1:1][DW-1:0] held;
  logic                   emit;

  for (genvar i = 1; i < LAT; i++) begin : g_track
    logic [DW-1:0] base;

    // A read leaving stage i-1 picks up a write committing on this edge
    assign fwd_hit[i] = commit && slot_is_read(st_vld[i-1], st_wr[i-1])
                        && (st_addr[i-1] == commit_addr);

    if (i == 1) begin : g_first
      assign base = arr_rdata;
    end else begin : g_later
      assign base = held[i-1];
    end

    always_ff @(posedge clk) begin
      held[i] <= fwd_hit[i] ? wr_data : base;
    end

    // R6: a forwarded word is the write data sampled on that edge
    assert_fwd_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_hit[i] |=> (held[i] == $past(wr_data)));
  end

  assign emit = slot_is_read(st_vld[LAT-1], st_wr[LAT-1]);

  // Pipelining register on the output bus
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= emit;
      if (emit) rd_data <= held[LAT-1];
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int unsigned AW  = 6,
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int unsigned LAST = LAT - 1;

  logic [LAT-1:0]         st_vld;
  logic [LAT-1:0]         st_wr;
  logic [LAT-1:0][AW-1:0] st_addr;
  logic                   commit;
  logic                   last_is_read;
  logic [AW-1:0]          commit_addr;
  logic [DW-1:0]          arr_rdata;
  logic [LAT-1:1]         fwd_hit;

  initial assert (LAT >= MIN_LAT);

  zbt_cmd_pipe #(.AW(AW), .LAT(LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .we      (we),
    .addr    (addr),
    .st_vld  (st_vld),
    .st_wr   (st_wr),
    .st_addr (st_addr)
  );

  // Named events: the write whose data is on the bus now, and the read leaving
  assign commit       = slot_is_write(st_vld[LAST], st_wr[LAST]);
  assign last_is_read = slot_is_read(st_vld[LAST], st_wr[LAST]);
  assign commit_addr  = st_addr[LAST];

  zbt_array #(.AW(AW), .DW(DW)) u_array (
    .clk       (clk),
    .mem_we    (commit),
    .mem_waddr (commit_addr),
    .mem_wdata (wr_data),
    .mem_raddr (st_addr[0]),
    .mem_rdata (arr_rdata)
  );

  zbt_read_track #(.AW(AW), .DW(DW), .LAT(LAT)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_vld      (st_vld),
    .st_wr       (st_wr),
    .st_addr     (st_addr),
    .commit      (commit),
    .commit_addr (commit_addr),
    .wr_data     (wr_data),
    .arr_rdata   (arr_rdata),
    .fwd_hit     (fwd_hit),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  // R2: a read reaching the last stage is on the output bus one edge later
  assert_read_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_is_read |=> rd_valid);

  // R1: a valid strobe only ever follows an accepted read
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(last_is_read));

  // R8: reset clears the output bus
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && rd_data == '0));

  // R9: the output word holds between results
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;

  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 2;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int due; logic [DW-1:0] word; } exp_t;
  exp_t          expq[$];
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] wdue [int];
  logic [DW-1:0] last_word = '0;

  zbt_sram #(.AW(AW), .DW(DW), .LAT(LAT)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2 clk = ~clk;  // 4 ns period
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 16'h0101) ^ (salt * 16'h3C05) ^ 16'h5A00);
  endfunction

  // Driver: one command per cycle; write data scheduled LAT edges later (R3)
  task automatic op(input bit c, input bit w, input int a, input logic [DW-1:0] d);
    int e;
    @(negedge clk);
    e = cyc + 1;
    ce = c; we = w; addr = AW'(a);
    // filler on the data bus when no write is due (R7)
    wr_data = wdue.exists(e) ? wdue[e] : (16'hDEAD ^ DW'(e * 7));
    if (c && w) begin
      ref_mem[a] = d;
      wdue[e + LAT] = d;
    end else if (c) begin
      expq.push_back('{due: e + LAT, word: ref_mem[a]});
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(1'b0, 1'b0, 0, '0);
  endtask

  // Monitor: pops expected results at their due cycle (R2 R4 R5), else checks quiet bus (R1 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        tests++;
        if (rd_valid !== 1'b1 || rd_data !== expq[0].word) begin
          fails++;
          $display("FAIL R2 R4 read result cyc %0d: actual valid=%b data=%h expected valid=1 data=%h",
                   cyc, rd_valid, rd_data, expq[0].word);
        end
        last_word = expq[0].word;
        void'(expq.pop_front());
      end else begin
        tests++;
        if (rd_valid !== 1'b0) begin
          fails++;
          $display("FAIL R1 spurious valid cyc %0d: actual=%b expected=0", cyc, rd_valid);
        end
        if (rd_data !== last_word) begin
          fails++;
          $display("FAIL R9 hold cyc %0d: actual=%h expected=%h", cyc, rd_data, last_word);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs cleared during reset
    tests++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R8 reset: actual valid=%b data=%h expected valid=0 data=0", rd_valid, rd_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 R2: fill every word back to back, then read all back to back
    for (int a = 0; a < NW; a++) op(1'b1, 1'b1, a, pat(a, 1));
    for (int a = 0; a < NW; a++) op(1'b1, 1'b0, a, '0);
    idle(3);

    // R5: alternate writes and reads on every cycle
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) op(1'b1, 1'b1, (k * 5) % NW, pat(k, 2));
      else            op(1'b1, 1'b0, (k * 3) % NW, '0);
    end
    idle(2);

    // R6: read right after a write to the same word, data still pending
    op(1'b1, 1'b1, 9, 16'hA1B2);
    op(1'b1, 1'b0, 9, '0);
    // R6: two pending writes to one word; the read must see the later one
    op(1'b1, 1'b1, 12, 16'h1111);
    op(1'b1, 1'b1, 12, 16'h2222);
    op(1'b1, 1'b0, 12, '0);
    // R3: read issued on the very edge the write data is taken
    op(1'b1, 1'b1, 20, 16'h3C3C);
    idle(1);
    op(1'b1, 1'b0, 20, '0);
    idle(3);

    // R1 R7: disabled commands with write asserted must not change memory
    op(1'b0, 1'b1, 5, '0);
    op(1'b0, 1'b1, 6, '0);
    op(1'b0, 1'b0, 7, '0);
    idle(3);
    op(1'b1, 1'b0, 5, '0);
    op(1'b1, 1'b0, 6, '0);
    op(1'b1, 1'b0, 7, '0);

    // R9: quiet bus for a while
    idle(8);

    // R5: every issued read has produced its result
    tests++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R5 drain: actual pending=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule